// File: doc/BRIEF.md
# Dual-CPU Doorbell Interrupt Unit

The doorbell unit lets two processors signal each other through memory-mapped registers. Each CPU owns a 4-bit pending-flag register. Any bus master can raise flags in that register by writing ones to a set alias, and can drop flags by writing ones to a clear alias. While a CPU's flag register holds any set bit, that CPU's level interrupt line stays high. The receiving CPU reads its flags and then clears the ones it has handled.

The register window is 4 KB on a 32-bit APB-style slave port. `pready` is tied high, so every access finishes in its access phase. The port raises `pslverr` for any illegal access: a read of a write-only alias, a write to a read-only word, or an offset that maps to nothing. A block of twelve read-only identification bytes sits at the top of the window. Only the slave port carries data, and it never applies back-pressure. The interrupt lines are plain level outputs.

Top module: `dbell_unit`

## Requirements
- R1: After reset, both flag registers read 0 and both `irq` bits are 0.
- R2: A write to the set alias of CPU n (offset 0x004 + 0x10·n) ORs `pwdata[3:0]` into that CPU's flags. `pwdata[31:4]` is ignored.
- R3: A write to the clear alias of CPU n (offset 0x008 + 0x10·n) clears each flag bit whose `pwdata[3:0]` bit is 1. All other flag bits keep their values.
- R4: `irq[n]` is 1 exactly when the flags of CPU n are non-zero. A write changes `irq` on the rising edge that ends the write's access phase, and not earlier.
- R5: A read of the status word of CPU n (offset 0x000 + 0x10·n) returns the flags in bits [3:0] with bits [31:4] at 0, and does not flag an error.
- R6: A read of a set or clear alias returns 0 and raises `pslverr`.
- R7: A write to a status word or to an identification word raises `pslverr` and leaves both flag registers unchanged.
- R8: Offsets 0xFD0 to 0xFFC, in steps of 4, read without error as the bytes 0x04, 0x00, 0x00, 0x00, 0x56, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in ascending address order, zero-extended to 32 bits.
- R9: Some offsets map to nothing: a non-word-aligned address (`paddr[1:0]` ≠ 0), word 3 of a CPU group (offset 0x00C + 0x10·n), and every offset outside the CPU groups and the identification block. Such offsets read 0, raise `pslverr` and ignore writes.
- R10: An access to one CPU's registers never changes the other CPU's flags or interrupt.
- R11: `pready` is always 1. `pslverr` is 0 outside an access phase (`psel` and `penable` both high). A setup phase on its own changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset in the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer done, constant 1 |
| pslverr | output | 1 | Illegal-access flag in the access phase |
| irq | output | 2 | Level interrupt per CPU, bit n for CPU n |

## Verification
The bench writes set data that has upper bits set, to check the mask. A design that leaked those bits would read back non-zero upper bits or corrupt flags. It performs partial clears that must leave the other flags standing, and a full clear that must drop `irq`. It samples `irq` both during the access phase and after the completing edge, which exposes a combinational or one-cycle-late interrupt. It also makes wrong-direction accesses, writes to status and identification words, and accesses at misaligned and unmapped offsets. A decoder that let any of these through would show either a missing error or a changed flag register. Finally, it holds a setup phase without an access phase, which catches strobes that are not gated by `penable`.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    RSEL_ZERO = 2'd0,
    RSEL_STAT = 2'd1,
    RSEL_ID   = 2'd2
  } rsel_e;
endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
  import dbell_pkg::*;
#(
  parameter int          NCPU     = 2,
  parameter int          ID_WORDS = 12,
  parameter logic [11:0] ID_BASE  = 12'hFD0,
  localparam int         IDX_W    = $clog2(ID_WORDS)
) (
  input  logic [ADDR_W-1:0] paddr,
  input  logic              pwrite,
  input  logic              access,
  output logic [NCPU-1:0]   set_we,
  output logic [NCPU-1:0]   clr_we,
  output logic [NCPU-1:0]   cpu_hit,
  output rsel_e             rsel,
  output logic [IDX_W-1:0]  id_idx,
  output logic              bad
);
  logic              aligned;
  logic              in_cpu;
  logic              in_id;
  logic [ADDR_W-1:0] id_off;
  logic [1:0]        fld;

  always_comb begin
    aligned = (paddr[1:0] == 2'b00);
    cpu_hit = '0;
    for (int i = 0; i < NCPU; i++) begin
      if (paddr[ADDR_W-1:4] == (ADDR_W-4)'(i)) cpu_hit[i] = aligned;
    end
    in_cpu = |cpu_hit;
    id_off = paddr - ID_BASE;
    in_id  = aligned && (paddr >= ID_BASE) &&
             (int'(id_off[ADDR_W-1:2]) < ID_WORDS);
    id_idx = id_off[IDX_W+1:2];
    fld    = paddr[3:2];

    rsel   = RSEL_ZERO;
    bad    = 1'b1;
    set_we = '0;
    clr_we = '0;
    if (in_cpu) begin
      case (fld)
        2'd0: if (!pwrite) begin rsel = RSEL_STAT; bad = 1'b0; end
        2'd1: if (pwrite) begin bad = 1'b0; set_we = cpu_hit & {NCPU{access}}; end
        2'd2: if (pwrite) begin bad = 1'b0; clr_we = cpu_hit & {NCPU{access}}; end
        default: bad = 1'b1;
      endcase
    end else if (in_id) begin
      if (!pwrite) begin rsel = RSEL_ID; bad = 1'b0; end
    end
  end
endmodule

// File: rtl/dbell_idrom.sv
module dbell_idrom #(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       idbyte
);
  always_comb begin
    case (int'(idx))
      0:  idbyte = 8'h04;
      1:  idbyte = 8'h00;
      2:  idbyte = 8'h00;
      3:  idbyte = 8'h00;
      4:  idbyte = 8'h56;
      5:  idbyte = 8'hB8;
      6:  idbyte = 8'h0B;
      7:  idbyte = 8'h00;
      8:  idbyte = 8'h0D;
      9:  idbyte = 8'hF0;
      10: idbyte = 8'h05;
      11: idbyte = 8'hB1;
      default: idbyte = 8'h00;
    endcase
  end
endmodule

// File: rtl/dbell_status.sv
module dbell_status #(
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] wbits,
  output logic [STAT_W-1:0] flags,
  output logic              irq
);
  logic [STAT_W-1:0] flags_nxt;

  always_comb begin
    flags_nxt = flags;
    if (set_we) flags_nxt = flags_nxt | wbits;
    if (clr_we) flags_nxt = flags_nxt & ~wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= flags_nxt;
      irq   <= |flags_nxt;
    end
  end

  // R2: a set write never removes a flag
  a_r2_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |=> ((flags & $past(flags)) == $past(flags)));
  // R3: a clear write leaves none of the named bits set
  a_r3_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((flags & $past(wbits)) == '0));
  // R10: no strobe, no change
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(flags));
  // R4: interrupt level mirrors non-zero flags
  a_r4_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (flags != '0));
endmodule

// File: rtl/dbell_unit.sv
module dbell_unit
  import dbell_pkg::*;
#(
  parameter int          NCPU     = 2,
  parameter int          STAT_W   = 4,
  parameter int          ID_WORDS = 12,
  parameter logic [11:0] ID_BASE  = 12'hFD0,
  localparam int         IDX_W    = $clog2(ID_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [NCPU-1:0]   irq
);
  logic                         access;
  logic [NCPU-1:0]              set_we, clr_we, cpu_hit;
  rsel_e                        rsel;
  logic [IDX_W-1:0]             id_idx;
  logic                         bad;
  logic [7:0]                   idbyte;
  logic [NCPU-1:0][STAT_W-1:0]  flags;
  logic [STAT_W-1:0]            stat_rd;
  logic                         unused_hi;

  assign access    = psel & penable;
  assign unused_hi = ^pwdata[DATA_W-1:STAT_W];

  dbell_decode #(.NCPU(NCPU), .ID_WORDS(ID_WORDS), .ID_BASE(ID_BASE)) u_dec (
    .paddr(paddr), .pwrite(pwrite), .access(access),
    .set_we(set_we), .clr_we(clr_we), .cpu_hit(cpu_hit),
    .rsel(rsel), .id_idx(id_idx), .bad(bad)
  );

  dbell_idrom #(.IDX_W(IDX_W)) u_id (.idx(id_idx), .idbyte(idbyte));

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    dbell_status #(.STAT_W(STAT_W)) u_stat (
      .clk(clk), .rst_n(rst_n),
      .set_we(set_we[g]), .clr_we(clr_we[g]),
      .wbits(pwdata[STAT_W-1:0]),
      .flags(flags[g]), .irq(irq[g])
    );
  end

  always_comb begin
    stat_rd = '0;
    for (int i = 0; i < NCPU; i++) begin
      if (cpu_hit[i]) stat_rd = stat_rd | flags[i];
    end
    case (rsel)
      RSEL_STAT: prdata = DATA_W'(stat_rd);
      RSEL_ID:   prdata = DATA_W'(idbyte);
      default:   prdata = '0;
    endcase
  end

  assign pready  = 1'b1;
  assign pslverr = access & bad;

  // R9: an errored read returns zero
  a_r9_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !pwrite && pslverr) |-> (prdata == '0));
  // R7: an errored write leaves every flag as it was
  a_r7_err_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (access && pwrite && pslverr) |=> $stable(flags));
  // R11: setup phase alone is inert
  a_r11_setup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |=> $stable(flags));
  // R10: one transfer touches at most one CPU
  a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_we | clr_we));
endmodule

// File: tb/dbell_unit_bench.sv
module dbell_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [1:0]  irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  dbell_unit u_dbell_unit (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .pready(pready), .pslverr(pslverr), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d,
                        output logic err, output logic [1:0] irq_pre);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1; #1; err = pslverr; irq_pre = irq;
    chk("R11 pready", {31'd0, pready}, 32'd1);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d, output logic err);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #1; d = prdata; err = pslverr;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic rd_expect(input string req, input logic [11:0] a,
                           input logic [31:0] exp_d, input logic exp_e);
    logic [31:0] d; logic e;
    apb_rd(a, d, e);
    chk(req, d, exp_d);
    chk({req, " err"}, {31'd0, e}, {31'd0, exp_e});
  endtask

  task automatic t_reset;
    chk("R1 irq", {30'd0, irq}, 32'd0);
    rd_expect("R1 stat0", 12'h000, 0, 0);
    rd_expect("R1 stat1", 12'h010, 0, 0);
  endtask

  task automatic t_set;
    logic e; logic [1:0] ip;
    apb_wr(12'h004, 32'hFFFF_FFF5, e, ip);
    chk("R2 set err", {31'd0, e}, 0);
    chk("R4 irq before edge", {30'd0, ip}, 0);
    chk("R4 irq after edge", {30'd0, irq}, 32'd1);
    rd_expect("R2 R5 masked", 12'h000, 32'h5, 0);
    apb_wr(12'h004, 32'h2, e, ip);
    rd_expect("R2 or", 12'h000, 32'h7, 0);
    rd_expect("R10 cpu1 untouched", 12'h010, 0, 0);
  endtask

  task automatic t_clr;
    logic e; logic [1:0] ip;
    apb_wr(12'h008, 32'hFFFF_FFF3, e, ip);
    chk("R3 clr err", {31'd0, e}, 0);
    rd_expect("R3 partial", 12'h000, 32'h4, 0);
    chk("R4 irq still high", {30'd0, irq}, 32'd1);
    apb_wr(12'h008, 32'hF, e, ip);
    chk("R4 irq before clear edge", {30'd0, ip}, 32'd1);
    chk("R4 irq dropped", {30'd0, irq}, 0);
    rd_expect("R3 all clear", 12'h000, 0, 0);
  endtask

  task automatic t_cpu1;
    logic e; logic [1:0] ip;
    apb_wr(12'h014, 32'h8, e, ip);
    chk("R10 irq", {30'd0, irq}, 32'd2);
    rd_expect("R2 cpu1", 12'h010, 32'h8, 0);
    rd_expect("R10 cpu0 stays", 12'h000, 0, 0);
    apb_wr(12'h008, 32'hF, e, ip);
    rd_expect("R10 cpu0 clr no effect on cpu1", 12'h010, 32'h8, 0);
  endtask

  task automatic t_wo_read;
    rd_expect("R6 set0", 12'h004, 0, 1);
    rd_expect("R6 clr1", 12'h018, 0, 1);
  endtask

  task automatic t_ro_write;
    logic e; logic [1:0] ip;
    apb_wr(12'h010, 32'h0, e, ip);
    chk("R7 stat write err", {31'd0, e}, 1);
    rd_expect("R7 stat kept", 12'h010, 32'h8, 0);
    apb_wr(12'h000, 32'hF, e, ip);
    rd_expect("R7 stat0 kept", 12'h000, 0, 0);
    apb_wr(12'hFE0, 32'h0, e, ip);
    chk("R7 id write err", {31'd0, e}, 1);
    rd_expect("R7 id kept", 12'hFE0, 32'h56, 0);
  endtask

  task automatic t_id;
    logic [7:0] exp_id [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h56, 8'hB8,
                                8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int k = 0; k < 12; k++)
      rd_expect("R8 id", 12'hFD0 + 12'(4 * k), {24'd0, exp_id[k]}, 0);
  endtask

  task automatic t_unmapped;
    logic e; logic [1:0] ip;
    rd_expect("R9 word3", 12'h00C, 0, 1);
    rd_expect("R9 cpu2 group", 12'h020, 0, 1);
    rd_expect("R9 mid", 12'h800, 0, 1);
    rd_expect("R9 misaligned", 12'h012, 0, 1);
    rd_expect("R9 below id", 12'hFCC, 0, 1);
    apb_wr(12'h01C, 32'hF, e, ip);
    chk("R9 write err", {31'd0, e}, 1);
    apb_wr(12'h005, 32'hF, e, ip);
    chk("R9 misaligned write err", {31'd0, e}, 1);
    rd_expect("R9 cpu0 kept", 12'h000, 0, 0);
    rd_expect("R9 cpu1 kept", 12'h010, 32'h8, 0);
  endtask

  task automatic t_setup_only;
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 12'h004; pwdata = 32'hF;
    repeat (3) begin
      @(negedge clk);
      chk("R11 no err in setup", {31'd0, pslverr}, 0);
    end
    psel = 0;
    chk("R11 irq unchanged", {30'd0, irq}, 32'd2);
    rd_expect("R11 cpu0 unchanged", 12'h000, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_set();
    t_clr();
    t_cpu1();
    t_wo_read();
    t_ro_write();
    t_id();
    t_unmapped();
    t_setup_only();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule